// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment/offset pair into a linear address. It works in one of two modes, chosen per request. In real-address mode the 16-bit segment is scaled by sixteen and the low 16 bits of the offset are added to it. The 20-bit sum is returned with no memory access, one cycle after the request is taken.

In protected mode the 16-bit value is a selector. Its upper thirteen bits index a table of 8-byte descriptors. Bit 2 picks the local table base (1) or the global table base (0). The two low bits play no part. The block reads the descriptor as two 32-bit words over a single-outstanding memory read port:

- The word at the descriptor address holds the segment base.
- The word four bytes above it holds the segment's byte limit.

If the 32-bit offset is within the limit, the block reports base plus offset. Otherwise it raises a fault and reports no address.

A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Each taken request ends with exactly one single-cycle pulse on `done` or on `fault`, and the result is carried on the registered `lin_addr`.

Top module: `seg_xlate`

## Requirements
- R1: Real mode (`req_prot`=0) gives `lin_addr` = (segment × 16 + offset[15:0]) mod 2^20, zero-extended to 32 bits. For example, 08F1h:0100h gives 00009010h, 028Fh:0030h gives 00002920h, and FFFFh:FFFFh gives 0000FFEFh.
- R2: A real-mode request raises `done` (with `fault` low) in the first cycle after the edge that takes it, and issues no memory read.
- R3: In real mode offset bits 31:16 have no effect on the result.
- R4: In protected mode the first read address is T + selector[15:3] × 8. T is `ltab_base` when selector bit 2 is 1 and `gtab_base` when it is 0. Selector bits 1:0 have no effect.
- R5: The descriptor is read as two words: the first at the descriptor address (the segment base), the second at that address + 4 (the byte limit). Only one read is outstanding at a time, and `mem_req_valid`/`mem_req_addr` hold steady until `mem_req_ready` takes them.
- R6: When offset ≤ limit, the protected request ends with `done` and `lin_addr` = (base + offset) mod 2^32.
- R7: When offset > limit, the request ends with `fault` high, `done` low and `lin_addr` = 0. An offset equal to the limit does not fault.
- R8: Each taken request gives exactly one single-cycle pulse on either `done` or `fault`, never both.
- R9: `req_ready` is low from the edge that takes a protected request until its result is reported.
- R10: After reset `req_ready`=1, while `done`, `fault`, `mem_req_valid` and `lin_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_prot | input | 1 | 1 = protected mode, 0 = real mode |
| req_sel | input | 16 | Segment (real mode) or selector (protected mode) |
| req_off | input | 32 | Offset; real mode uses bits 15:0 only |
| gtab_base | input | 32 | Global descriptor table base address |
| ltab_base | input | 32 | Local descriptor table base address |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned descriptor word |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: offset beyond segment limit |
| lin_addr | output | 32 | Linear address result (0 after a fault) |

## Verification
Some internal faults show up at the first memory read, in the address and its hold behaviour. A wrong table select, index scaling or second-word step gives a wrong `mem_req_addr` on the first or second read of a protected request. The bench compares both addresses against its own descriptor-address model.

A base word latched in the wrong place, or an off-by-one limit compare, is seen only at completion. The `done`/`fault` choice and `lin_addr` are then wrong a cycle after the second read returns. The directed cases with offset equal to the limit and offset one past it expose an off-by-one compare directly.

A stuck controller state holds `req_ready` low or never ends the request. The bench catches this within a few hundred cycles.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_BASE_REQ,
    XS_BASE_WAIT,
    XS_LIM_REQ,
    XS_LIM_WAIT
  } xl_state_e;
endpackage

// File: rtl/seg_real_add.sv
module seg_real_add #(
  parameter int SEG_W   = 16,
  parameter int ROFF_W  = 16,
  parameter int SHIFT   = 4,
  parameter int RADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]   seg,
  input  logic [ROFF_W-1:0]  off,
  output logic [RADDR_W-1:0] lin
);
  logic [RADDR_W-1:0] seg_scaled;
  logic [RADDR_W-1:0] off_ext;

  always_comb begin
    seg_scaled = RADDR_W'({seg, {SHIFT{1'b0}}});
    off_ext    = RADDR_W'(off);
    lin        = seg_scaled + off_ext;   // carry beyond RADDR_W is dropped
  end
endmodule

// File: rtl/seg_desc_addr.sv
module seg_desc_addr #(
  parameter int IDX_W     = 13,
  parameter int ADDR_W    = 32,
  parameter int DESC_LOG2 = 3
) (
  input  logic [IDX_W-1:0]  index,
  input  logic              use_local,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [ADDR_W-1:0] lbase,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [ADDR_W-1:0] tbl;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    tbl       = use_local ? lbase : gbase;
    scaled    = ADDR_W'(index) << DESC_LOG2;
    desc_addr = tbl + scaled;
  end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] off,
  input  logic [ADDR_W-1:0] limit,
  output logic              over,
  output logic [ADDR_W-1:0] sum
);
  always_comb begin
    over = off > limit;
    sum  = base + off;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REAL_OFF_W = 16,
  parameter int SHIFT      = 4,
  parameter int TI_BIT     = 2,
  parameter int DESC_LOG2  = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_prot,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [ADDR_W-1:0] ltab_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] lin_addr
);
  localparam int RADDR_W = SEL_W + SHIFT;
  localparam int IDX_LSB = TI_BIT + 1;
  localparam int IDX_W   = SEL_W - IDX_LSB;

  xl_state_e          state_q;
  logic [ADDR_W-1:0]  desc_q, off_q, base_q, lin_q;
  logic               done_q, fault_q;
  logic [RADDR_W-1:0] real_lin;
  logic [ADDR_W-1:0]  desc_addr;
  logic               over;
  logic [ADDR_W-1:0]  prot_sum;
  logic               unused_bits;

  assign unused_bits = ^{req_sel[TI_BIT-1:0], req_off[ADDR_W-1:REAL_OFF_W]};

  seg_real_add #(
    .SEG_W(SEL_W), .ROFF_W(REAL_OFF_W), .SHIFT(SHIFT), .RADDR_W(RADDR_W)
  ) u_real (
    .seg(req_sel), .off(req_off[REAL_OFF_W-1:0]), .lin(real_lin)
  );

  seg_desc_addr #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_LOG2(DESC_LOG2)
  ) u_daddr (
    .index(req_sel[SEL_W-1:IDX_LSB]), .use_local(req_sel[TI_BIT]),
    .gbase(gtab_base), .lbase(ltab_base), .desc_addr(desc_addr)
  );

  seg_limit_chk #(.ADDR_W(ADDR_W)) u_lim (
    .base(base_q), .off(off_q), .limit(mem_rsp_data), .over(over), .sum(prot_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      desc_q  <= '0;
      off_q   <= '0;
      base_q  <= '0;
      lin_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (req_valid) begin
            if (!req_prot) begin
              done_q <= 1'b1;
              lin_q  <= ADDR_W'(real_lin);
            end else begin
              desc_q  <= desc_addr;
              off_q   <= req_off;
              state_q <= XS_BASE_REQ;
            end
          end
        end
        XS_BASE_REQ:  if (mem_req_ready) state_q <= XS_BASE_WAIT;
        XS_BASE_WAIT: begin
          if (mem_rsp_valid) begin
            base_q  <= mem_rsp_data;
            state_q <= XS_LIM_REQ;
          end
        end
        XS_LIM_REQ:   if (mem_req_ready) state_q <= XS_LIM_WAIT;
        XS_LIM_WAIT: begin
          if (mem_rsp_valid) begin
            if (over) begin
              fault_q <= 1'b1;
              lin_q   <= '0;
            end else begin
              done_q <= 1'b1;
              lin_q  <= prot_sum;
            end
            state_q <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state_q == XS_IDLE);
    mem_req_valid = (state_q == XS_BASE_REQ) || (state_q == XS_LIM_REQ);
    mem_req_addr  = (state_q == XS_LIM_REQ) ? desc_q + ADDR_W'(WORD_BYTES) : desc_q;
    done          = done_q;
    fault         = fault_q;
    lin_addr      = lin_q;
  end
endmodule

module seg_xlate_chk #(
  parameter int ADDR_W  = 32,
  parameter int RADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_prot,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] lin_addr
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_fault_noaddr_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> lin_addr == '0);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_real_lat_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_prot) |=> (done && !fault && !mem_req_valid));

  assert_real_width_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_prot) |=> (lin_addr[ADDR_W-1:RADDR_W] == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .RADDR_W(SEL_W + SHIFT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_prot(req_prot), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .fault(fault), .lin_addr(lin_addr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_prot = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [31:0] gtab_base = 32'h0000_1000, ltab_base = 32'h0000_1200;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [31:0] lin_addr;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [31:0] dmem [0:255];
  logic [31:0] addr_log [0:1];
  int n_acc = 0;

  always #5 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_prot(req_prot), .req_sel(req_sel), .req_off(req_off),
    .gtab_base(gtab_base), .ltab_base(ltab_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .lin_addr(lin_addr)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return dmem[a[9:2]];
  endfunction

  function automatic logic [31:0] exp_real(input logic [15:0] s, input logic [31:0] o);
    logic [19:0] r;
    r = {s, 4'h0} + {4'h0, o[15:0]};
    return {12'h0, r};
  endfunction

  function automatic logic [31:0] exp_daddr(input logic [15:0] s);
    return (s[2] ? ltab_base : gtab_base) + {16'h0, s[15:3], 3'b000};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: random ready, response 1..3 cycles after acceptance
  initial begin
    int pend = 0;
    logic [31:0] paddr = '0;
    bit acc = 0;
    logic [31:0] aaddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend != 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word_at(paddr);
        end
      end
      if (acc) begin
        pend  = 1 + int'($urandom % 3);
        paddr = aaddr;
        acc   = 0;
      end
      mem_req_ready = (pend == 0) ? 1'($urandom % 2) : 1'b0;
      if (mem_req_valid && mem_req_ready && !rst) begin
        acc   = 1;
        aaddr = mem_req_addr;
        if (n_acc < 2) addr_log[n_acc] = mem_req_addr;
        n_acc++;
      end
    end
  end

  task automatic xact(input bit prot, input logic [15:0] sel, input logic [31:0] off,
                      output bit gd, output bit gf, output logic [31:0] la, output int lat);
    bit busy_bad;
    busy_bad = 0;
    n_acc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_prot = prot; req_sel = sel; req_off = off;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!(done || fault) && lat < 200) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      lat++;
    end
    gd = done; gf = fault; la = lin_addr;
    if (prot) chk(!busy_bad, "R9 req_ready low while busy", 32'(busy_bad), 32'h0);
    @(negedge clk);
    chk(!done && !fault, "R8 single pulse", {30'h0, done, fault}, 32'h0);
  endtask

  task automatic run_real(input logic [15:0] s, input logic [31:0] o, input string tag);
    bit gd, gf; logic [31:0] la; int lat;
    xact(1'b0, s, o, gd, gf, la, lat);
    chk(gd && !gf, {tag, " done"}, {30'h0, gd, gf}, 32'h2);
    chk(lat == 0, "R2 real latency", 32'(lat), 32'h0);
    chk(n_acc == 0, "R2 no memory read", 32'(n_acc), 32'h0);
    chk(la == exp_real(s, o), tag, la, exp_real(s, o));
  endtask

  task automatic run_prot(input logic [15:0] s, input logic [31:0] o, input string tag);
    bit gd, gf; logic [31:0] la; int lat;
    logic [31:0] da, b, l;
    da = exp_daddr(s); b = word_at(da); l = word_at(da + 32'd4);
    xact(1'b1, s, o, gd, gf, la, lat);
    chk(n_acc == 2, "R5 two reads", 32'(n_acc), 32'd2);
    chk(addr_log[0] == da, "R4 descriptor address", addr_log[0], da);
    chk(addr_log[1] == da + 32'd4, "R5 limit word address", addr_log[1], da + 32'd4);
    if (o > l) begin
      chk(gf && !gd, {tag, " R7 fault"}, {30'h0, gd, gf}, 32'h1);
      chk(la == 32'h0, "R7 no address on fault", la, 32'h0);
    end else begin
      chk(gd && !gf, {tag, " R6 done"}, {30'h0, gd, gf}, 32'h2);
      chk(la == b + o, {tag, " R6 linear"}, la, b + o);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0001));
    for (int i = 0; i < 256; i++) dmem[i] = $urandom;
    // global entry 1: base 0x0040_0000, limit 0x0000_0FFF
    dmem[(32'h1000 + 8) >> 2 & 255]     = 32'h0040_0000;
    dmem[(32'h1000 + 12) >> 2 & 255]    = 32'h0000_0FFF;
    // local entry 2: base 0xFFFF_F000, limit 0xFFFF_FFFF
    dmem[(32'h1200 + 16) >> 2 & 255]    = 32'hFFFF_F000;
    dmem[(32'h1200 + 20) >> 2 & 255]    = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !done && !fault && !mem_req_valid && lin_addr == 0, "R10 reset state",
        {req_ready, done, fault, mem_req_valid, lin_addr[27:0]}, 32'h8000_0000);

    // R1 directed
    run_real(16'h08F1, 32'h0000_0100, "R1 08F1:0100");
    run_real(16'h028F, 32'h0000_0030, "R1 028F:0030");
    run_real(16'hFFFF, 32'h0000_FFFF, "R1 wrap past bit 19");
    // R3 upper offset bits ignored
    run_real(16'h08F1, 32'hABCD_0100, "R3 upper offset ignored");

    // R6/R7 boundaries, R4 table select and low selector bits
    run_prot(16'h0008, 32'h0000_0FFF, "R7 offset equals limit");
    run_prot(16'h0008, 32'h0000_1000, "R7 offset one past limit");
    run_prot(16'h000B, 32'h0000_0123, "R4 low selector bits ignored");
    run_prot(16'h0014, 32'h0000_2000, "R6 local table wrap");

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [15:0] s; logic [31:0] o;
      s = 16'($urandom);
      o = ($urandom % 4 == 0) ? word_at(exp_daddr(s) + 32'd4) + 32'(($urandom % 3)) - 32'd1
                              : $urandom;
      if ($urandom % 2) run_real(s, o, "R1 random real");
      else              run_prot(s, o, "R6 random protected");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog R8 act=%h exp=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule